// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-drop decision for each incoming Ethernet frame. For every frame it is given the 48-bit destination address, a runt indication, CRC and alignment error flags, and a 6-bit hash index computed elsewhere. It compares these against a station address, a 64-bit group hash table and a configuration byte. It then reports whether the frame is kept, and whether the frame was kept through a group (multicast or broadcast) match or through a physical match.

Software loads the station address, the hash table and the configuration over a byte-wide write port. There is one write per cycle, at a 4-bit register address. A frame is presented for one cycle with `frm_valid` high. The decision appears on the registered outputs on the next cycle. Frame storage and the CRC calculation lie outside the block.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `acc_valid`, `acc_take` and `acc_group` are 0. `acc_valid` is high exactly in the cycle after a cycle with `frm_valid` high, and `acc_take`/`acc_group` are 0 whenever `acc_valid` is 0.
- R2: Configuration bit 0 (keep-errored) controls frames with `frm_crc_err` or `frm_align_err` set. When bit 0 is 0 such frames are not taken. When bit 0 is 1 the error flags have no effect on the decision.
- R3: Configuration bit 1 (runt-ok) controls frames with `frm_runt` set. When bit 1 is 0 such frames are not taken. When bit 1 is 1 the runt flag has no effect.
- R4: A destination of all ones is a broadcast. It passes the address check only when configuration bit 2 is 1, and the hash table is not consulted for it.
- R5: A destination whose first byte has bit 0 set (`frm_dst[40]`) and that is not broadcast is a multicast. It passes only when configuration bit 3 is 1 and hash bit `frm_hash_idx` is 1. Hash register k (address 6+k, k = 0..7) holds hash bits 8k+7..8k, so byte `idx[5:3]`, bit `idx[2:0]`.
- R6: A destination with `frm_dst[40]` = 0 is physical. It passes when configuration bit 4 (promiscuous) is 1, or when it equals the station address. Station byte k sits at address k (k = 0..5), and byte 0 is compared with `frm_dst[47:40]`.
- R7: `acc_group` is 1 when a frame is taken through the broadcast or multicast path, and 0 for a frame taken through the physical path.
- R8: Configuration bit 5 (monitor) forces `acc_take` and `acc_group` to 0 for every frame, while `acc_valid` still follows `frm_valid`.
- R9: Configuration is written at address 14. Bits 7 and 6 of that write have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0-5 station, 6-13 hash, 14 config) |
| cfg_wdata | input | 8 | Register write data |
| frm_valid | input | 1 | Frame descriptor valid for this cycle |
| frm_dst | input | 48 | Destination address, first byte in bits 47:40 |
| frm_hash_idx | input | 6 | Hash table index for this destination |
| frm_runt | input | 1 | Frame shorter than 64 bytes |
| frm_crc_err | input | 1 | Frame has a CRC error |
| frm_align_err | input | 1 | Frame has an alignment error |
| acc_valid | output | 1 | Decision valid (one cycle after frm_valid) |
| acc_take | output | 1 | Frame is kept |
| acc_group | output | 1 | Kept through a broadcast/multicast match |

## Verification
Destinations are drawn from five classes: exact station match, station with one flipped non-group bit, broadcast, random multicast and random unicast. Each class is crossed with random configuration bytes, random hash tables and random runt and error flags. The one-bit-off station address separates a true per-byte compare from a partial one. Broadcast set against an empty hash table shows that the hash is bypassed for all-ones. Directed cases set single hash bits and their neighbours to fix the byte and bit ordering of the index. They also toggle each of the keep-errored, runt-ok and monitor controls around an otherwise accepted frame, and set only the reserved configuration bits, so that each control is seen to act alone.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int STA_BYTES  = 6;
    localparam int HASH_BITS  = 64;
    localparam int HASH_BYTES = HASH_BITS / 8;
    localparam int IDX_W      = $clog2(HASH_BITS);
    localparam int ADDR_W     = 4;
    localparam int CFG_W      = 6;
    localparam int HASH_BASE  = STA_BYTES;
    localparam int CFG_ADDR   = HASH_BASE + HASH_BYTES;

    // configuration bit positions
    localparam int C_KEEP_ERR = 0;
    localparam int C_RUNT_OK  = 1;
    localparam int C_BCAST    = 2;
    localparam int C_MCAST    = 3;
    localparam int C_PROMISC  = 4;
    localparam int C_MONITOR  = 5;

    typedef struct packed {
        logic [STA_BYTES*8-1:0] sta;
        logic [HASH_BITS-1:0]   hash;
        logic [CFG_W-1:0]       cfg;
    } regs_t;

    typedef struct packed {
        logic valid;
        logic take;
        logic group;
    } dec_t;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [STA_BYTES*8-1:0] sta,
    output logic [HASH_BITS-1:0]   hash,
    output logic [CFG_W-1:0]       cfg
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            for (int k = 0; k < STA_BYTES; k++) begin
                if (addr == ADDR_W'(k))
                    r_d.sta[8*(STA_BYTES-1-k) +: 8] = wdata;
            end
            for (int k = 0; k < HASH_BYTES; k++) begin
                if (addr == ADDR_W'(HASH_BASE + k))
                    r_d.hash[8*k +: 8] = wdata;
            end
            if (addr == ADDR_W'(CFG_ADDR))
                r_d.cfg = wdata[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sta  = r_q.sta;
    assign hash = r_q.hash;
    assign cfg  = r_q.cfg;
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  logic [STA_BYTES*8-1:0] dst,
    input  logic [IDX_W-1:0]       idx,
    input  logic [STA_BYTES*8-1:0] sta,
    input  logic [HASH_BITS-1:0]   hash,
    input  logic [CFG_W-1:0]       cfg,
    input  logic                   runt,
    input  logic                   crc_err,
    input  logic                   align_err,
    output logic                   take,
    output logic                   group
);
    localparam int GRP_BIT = STA_BYTES*8 - 8;

    logic [STA_BYTES-1:0] byte_eq;
    logic                 is_grp, is_bcast, addr_hit, qual_ok;

    // per-byte comparators of the station address
    for (genvar k = 0; k < STA_BYTES; k++) begin : g_eq
        assign byte_eq[k] = (dst[8*k +: 8] == sta[8*k +: 8]);
    end

    always_comb begin
        is_grp   = dst[GRP_BIT];
        is_bcast = &dst;
        if (is_grp) begin
            // broadcast is decided before any hash lookup
            if (is_bcast) addr_hit = cfg[C_BCAST];
            else          addr_hit = cfg[C_MCAST] & hash[idx];
        end else begin
            addr_hit = cfg[C_PROMISC] | (&byte_eq);
        end
        qual_ok = (cfg[C_KEEP_ERR] | ~(crc_err | align_err))
                & (cfg[C_RUNT_OK]  | ~runt)
                & ~cfg[C_MONITOR];
        take  = addr_hit & qual_ok;
        group = take & is_grp;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        frm_valid,
    input  logic [47:0] frm_dst,
    input  logic [5:0]  frm_hash_idx,
    input  logic        frm_runt,
    input  logic        frm_crc_err,
    input  logic        frm_align_err,
    output logic        acc_valid,
    output logic        acc_take,
    output logic        acc_group
);
    logic [STA_BYTES*8-1:0] sta_w;
    logic [HASH_BITS-1:0]   hash_w;
    logic [CFG_W-1:0]       cfg_w;
    logic                   m_take, m_group;
    dec_t                   dec_d, dec_q;

    rxf_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .sta   (sta_w),
        .hash  (hash_w),
        .cfg   (cfg_w)
    );

    rxf_match u_match (
        .dst       (frm_dst),
        .idx       (frm_hash_idx),
        .sta       (sta_w),
        .hash      (hash_w),
        .cfg       (cfg_w),
        .runt      (frm_runt),
        .crc_err   (frm_crc_err),
        .align_err (frm_align_err),
        .take      (m_take),
        .group     (m_group)
    );

    always_comb begin
        dec_d.valid = frm_valid;
        dec_d.take  = frm_valid & m_take;
        dec_d.group = frm_valid & m_group;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign acc_valid = dec_q.valid;
    assign acc_take  = dec_q.take;
    assign acc_group = dec_q.group;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_valid,
    input logic [47:0] frm_dst,
    input logic        frm_runt,
    input logic        frm_crc_err,
    input logic        frm_align_err,
    input logic [5:0]  cfg,
    input logic        acc_valid,
    input logic        acc_take,
    input logic        acc_group
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> acc_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !acc_valid);
    // R1
    take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_take |-> acc_valid);
    // R2
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_crc_err || frm_align_err) && !cfg[0]) |=> !acc_take);
    // R3
    runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_runt && !cfg[1]) |=> !acc_take);
    // R4
    bcast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (&frm_dst) && !cfg[2]) |=> !acc_take);
    // R7
    group_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_group |-> acc_take);
    // R7
    phys_not_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_dst[40]) |=> !acc_group);
    // R8
    monitor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && cfg[5]) |=> !acc_take);
endmodule

bind rx_addr_filter rxf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_valid     (frm_valid),
    .frm_dst       (frm_dst),
    .frm_runt      (frm_runt),
    .frm_crc_err   (frm_crc_err),
    .frm_align_err (frm_align_err),
    .cfg           (cfg_w),
    .acc_valid     (acc_valid),
    .acc_take      (acc_take),
    .acc_group     (acc_group)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [5:0]  frm_hash_idx = '0;
    logic        frm_runt = 1'b0;
    logic        frm_crc_err = 1'b0;
    logic        frm_align_err = 1'b0;
    logic        acc_valid, acc_take, acc_group;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the register contents
    logic [7:0] m_sta [6];
    logic [7:0] m_hash [8];
    logic [7:0] m_cfg;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (.*);

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: valid/take/group actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 4'd6) m_sta[a] = d;
        else if (a < 4'd14) m_hash[a - 4'd6] = d;
        else if (a == 4'd14) m_cfg = d;
    endtask

    function automatic logic [47:0] sta_addr();
        return {m_sta[0], m_sta[1], m_sta[2], m_sta[3], m_sta[4], m_sta[5]};
    endfunction

    // expected {take, group} from the requirements
    function automatic logic [1:0] model(logic [47:0] d, logic [5:0] idx,
                                         logic runt, logic crc, logic aln);
        logic hit, grp, ok;
        grp = d[40];
        if (grp) begin
            if (d == '1) hit = m_cfg[2];
            else         hit = m_cfg[3] && m_hash[idx[5:3]][idx[2:0]];
        end else begin
            hit = m_cfg[4] || (d == sta_addr());
        end
        ok = (m_cfg[0] || !(crc || aln)) && (m_cfg[1] || !runt) && !m_cfg[5];
        return {hit && ok, hit && ok && grp};
    endfunction

    task automatic frame(string req, logic [47:0] d, logic [5:0] idx,
                         logic runt, logic crc, logic aln);
        logic [1:0] e;
        e = model(d, idx, runt, crc, aln);
        frm_valid = 1'b1; frm_dst = d; frm_hash_idx = idx;
        frm_runt = runt; frm_crc_err = crc; frm_align_err = aln;
        @(negedge clk);
        frm_valid = 1'b0;
        chk(req, {acc_valid, acc_take, acc_group}, {1'b1, e});
    endtask

    function automatic logic [47:0] pick_dst(int cls);
        logic [47:0] r;
        r = {$urandom, $urandom};
        case (cls)
            0: return sta_addr();
            1: return sta_addr() ^ (48'd1 << ($urandom % 40));
            2: return '1;
            3: return r | (48'd1 << 40);
            default: return r & ~(48'd1 << 40);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1: watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] st;
        void'($urandom(32'h5EED_0042));
        foreach (m_sta[k]) m_sta[k] = '0;
        foreach (m_hash[k]) m_hash[k] = '0;
        m_cfg = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {acc_valid, acc_take, acc_group}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {acc_valid, acc_take, acc_group}, 3'b000);

        st = {$urandom, $urandom} & ~(48'd1 << 40);
        for (int k = 0; k < 6; k++) wr(4'(k), st[8*(5-k) +: 8]);
        for (int k = 0; k < 8; k++) wr(4'(6 + k), 8'h00);
        wr(4'd14, 8'h00);

        // R6 exact station match taken as physical (R7 group=0)
        frame("R6/R7 station", sta_addr(), 6'd0, 0, 0, 0);
        // R6 one byte off -> dropped
        frame("R6 last byte off", sta_addr() ^ 48'h0000_0000_0001, 6'd0, 0, 0, 0);
        frame("R6 first byte off", sta_addr() ^ 48'h8000_0000_0000, 6'd0, 0, 0, 0);
        // R1 no frame -> valid low
        @(negedge clk);
        chk("R1 gap", {acc_valid, acc_take, acc_group}, 3'b000);
        // R2 errored dropped, then kept with bit 0
        frame("R2 crc drop", sta_addr(), 6'd0, 0, 1, 0);
        frame("R2 align drop", sta_addr(), 6'd0, 0, 0, 1);
        wr(4'd14, 8'h01);
        frame("R2 crc keep", sta_addr(), 6'd0, 0, 1, 1);
        // R3 runt
        frame("R3 runt drop", sta_addr(), 6'd0, 1, 0, 0);
        wr(4'd14, 8'h02);
        frame("R3 runt keep", sta_addr(), 6'd0, 1, 0, 0);
        // R4 broadcast, hash empty
        frame("R4 bcast off", '1, 6'd63, 0, 0, 0);
        wr(4'd14, 8'h04);
        frame("R4/R7 bcast on", '1, 6'd63, 0, 0, 0);
        // R5 hash ordering: byte 2 bit 2 -> index 18
        wr(4'd8, 8'h04);
        wr(4'd14, 8'h08);
        frame("R5 hash hit", 48'h0100_0000_0000, 6'd18, 0, 0, 0);
        frame("R5 hash neighbour", 48'h0100_0000_0000, 6'd19, 0, 0, 0);
        frame("R5 hash other byte", 48'h0100_0000_0000, 6'd10, 0, 0, 0);
        frame("R4 bcast via hash bit only", '1, 6'd18, 0, 0, 0);
        wr(4'd14, 8'h00);
        frame("R5 mcast disabled", 48'h0100_0000_0000, 6'd18, 0, 0, 0);
        // R6 promiscuous
        wr(4'd14, 8'h10);
        frame("R6 promisc", 48'h0200_1234_5678, 6'd0, 0, 0, 0);
        // R8 monitor
        wr(4'd14, 8'h3F);
        frame("R8 monitor station", sta_addr(), 6'd0, 0, 0, 0);
        frame("R8 monitor bcast", '1, 6'd0, 0, 0, 0);
        // R9 reserved bits only
        wr(4'd14, 8'hC0);
        frame("R9 reserved bits", '1, 6'd0, 0, 0, 0);
        frame("R9 reserved station", sta_addr(), 6'd0, 1, 0, 0);

        // random phase
        for (int n = 0; n < 2000; n++) begin
            if (n % 25 == 0) begin
                for (int k = 0; k < 8; k++) wr(4'(6 + k), 8'($urandom));
                wr(4'd14, 8'($urandom) & ((n % 50 == 0) ? 8'hDF : 8'hFF));
            end
            frame("R2-R9 random", pick_dst($urandom % 5), 6'($urandom),
                  ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule